// File: doc/BRIEF.md
# Two-Bank Edge/Level Interrupt Controller

This block gathers up to 64 interrupt inputs, arranged as two banks of 32, and drives one registered interrupt request to a processor. Each bank has a small register set behind a 64-byte window. Software can read latched edge flags, read and write a per-source enable mask, clear flags by writing ones, and sample the raw synchronized input state. Software finds the highest pending bit by reading the registers. The block does no vectoring.

Most sources are edge-triggered. A rising edge on the synchronized input latches a flag while that source is enabled, and the flag stays set until software clears it. A fixed group of sources in the first bank is level-triggered. These have no flag: while the input is high and enabled, it requests service directly. A parameter selects one of two widths for that level group.

Top module: `irq_banked_ctrl`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), every enable bit and every edge flag is 0 and irq_o is 0.
- R2: The enable register (word offset 1, byte 0x4 within a bank) reads back the last value written to it. Bit n is source n of that bank.
- R3: An edge source whose enable bit is 1 sets its flag in the event register (word offset 0) three clock edges after its input rises: two synchronizer stages, then the edge detector.
- R4: A rising edge on a disabled source latches nothing. Enabling a source whose input is already high sets no flag and raises no request.
- R5: Writing the acknowledge register (word offset 2) clears every flag whose data bit is 1 and leaves flags under 0 bits unchanged. The register reads as 0.
- R6: When an acknowledge write and a fresh rising edge hit the same bit in the same cycle, the flag stays set.
- R7: The level register (word offset 3) shows all 32 inputs of the bank after the two-stage synchronizer.
- R8: Bank-0 sources 20..29 (mask 0x3FF00000), or 20..28 (mask 0x1FF00000) when ALT_LEVEL is 1, are level-triggered. They never set a flag, and they request service while synchronized-high and enabled.
- R9: irq_o is high one cycle after any bank has a source whose (flag OR masked level) AND enable is 1.
- R10: Bank 0 decodes at bytes 0x20..0x2F and bank 1 at 0x10..0x1F. Reads elsewhere in the window return 0, and writes elsewhere have no effect.
- R11: Writing 0 to the enable registers stops the request within two cycles. Flags already latched stay readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Word address, byte address bits 5..2 |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for reg_addr |
| src_i | input | 64 | Interrupt inputs, bit 32*b+n is bank b source n |
| irq_o | output | 1 | Registered interrupt request |

## Verification
A flag that latches wrongly, or survives an acknowledge it should not survive, shows on irq_o one cycle after the edge-detect stage. It also shows in the event read on the very next access. An enable register that takes the wrong value shows at once on readback, and shows on the request one cycle later. A wrong level mask only becomes visible when a source inside or next to the 20..29 group is driven high. Because of that, the stimulus covers bits on both sides of the group boundary, and the reference model is compared with the request and read data on every cycle.

// File: rtl/irq_pkg.sv
// Shared constants for the banked interrupt controller.
// Assumes 32-bit banks and a four-register layout inside each bank.
package irq_pkg;
    typedef enum logic [1:0] {
        REG_EVENT  = 2'd0,
        REG_ENABLE = 2'd1,
        REG_ACK    = 2'd2,
        REG_LEVEL  = 2'd3
    } reg_sel_e;

    localparam logic [31:0] LVL_MASK_WIDE   = 32'h3FF0_0000;
    localparam logic [31:0] LVL_MASK_NARROW = 32'h1FF0_0000;

    // Level-source mask for a bank: only bank 0 carries level sources.
    function automatic logic [31:0] level_mask_f(int bank, bit alt);
        if (bank != 0) return 32'h0;
        return alt ? LVL_MASK_NARROW : LVL_MASK_WIDE;
    endfunction
endpackage

// File: rtl/irq_sync.sv
// Two-flop synchronizer for a vector of asynchronous inputs.
// Assumes each bit is independent; no cross-bit coherence is given.
module irq_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Two register stages, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/irq_bank.sv
// One bank of sources: enable mask, edge flags, level pass-through.
// Assumes lvl_sync is already synchronized. LVL_MASK marks the
// level-triggered bits; every other bit is edge-triggered.
module irq_bank #(
    parameter int          W        = 32,
    parameter logic [31:0] LVL_MASK = 32'h0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_sync,
    input  logic         en_we,
    input  logic         ack_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] en_q,
    output logic [W-1:0] ev_q,
    output logic [W-1:0] rise,
    output logic         pend
);
    localparam logic [W-1:0] LMASK = LVL_MASK[W-1:0];

    logic [W-1:0] prev_q;
    logic [W-1:0] clr;
    logic [W-1:0] ev_nxt;

    // Edge detector on edge-type bits only.
    always_comb rise = lvl_sync & ~prev_q & ~LMASK;

    // Acknowledge bits to clear this cycle.
    always_comb clr = ack_we ? wdata : '0;

    // Flag update: new enabled edges win over a clear.
    always_comb ev_nxt = (ev_q & ~clr) | (rise & en_q);

    // Bank request: flags plus masked level bits, gated by enable.
    always_comb pend = |((ev_q | (lvl_sync & LMASK)) & en_q);

    // Previous synchronized sample for the edge detector.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl_sync;
    end

    // Enable register, written whole.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (en_we) en_q <= wdata;
    end

    // Edge flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) ev_q <= '0;
        else        ev_q <= ev_nxt;
    end
endmodule

// File: rtl/irq_banked_ctrl.sv
// Top of the banked interrupt controller: address decode, read mux,
// synchronizers, banks and the registered request. Assumes bank b sits
// at byte offset (NUM_BANKS-b)*16 and a word-addressed write strobe.
module irq_banked_ctrl #(
    parameter int NUM_BANKS = 2,
    parameter int BANK_W    = 32,
    parameter int ADDR_W    = 6,
    parameter bit ALT_LEVEL = 1'b0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:2]           reg_addr,
    input  logic [BANK_W-1:0]           wdata,
    output logic [BANK_W-1:0]           rdata,
    input  logic [NUM_BANKS*BANK_W-1:0] src_i,
    output logic                        irq_o
);
    import irq_pkg::*;

    localparam int NSRC  = NUM_BANKS * BANK_W;
    localparam int SEL_W = ADDR_W - 4;

    logic [NSRC-1:0]      sync_all;
    logic [NSRC-1:0]      en_all;
    logic [NSRC-1:0]      ev_all;
    logic [NSRC-1:0]      rise_all;
    logic [NUM_BANKS-1:0] pend_bank;
    logic [NUM_BANKS-1:0] hit;
    logic                 pend_any;
    reg_sel_e             rsel;

    always_comb rsel = reg_sel_e'(reg_addr[3:2]);

    irq_sync #(.W(NSRC)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (src_i),
        .q     (sync_all)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam logic [SEL_W-1:0] BSEL = SEL_W'(NUM_BANKS - b);

        // Bank hit from the upper address bits.
        always_comb hit[b] = (reg_addr[ADDR_W-1:4] == BSEL);

        irq_bank #(
            .W        (BANK_W),
            .LVL_MASK (level_mask_f(b, ALT_LEVEL))
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .lvl_sync (sync_all[b*BANK_W +: BANK_W]),
            .en_we    (wr_en && hit[b] && rsel == REG_ENABLE),
            .ack_we   (wr_en && hit[b] && rsel == REG_ACK),
            .wdata    (wdata),
            .en_q     (en_all[b*BANK_W +: BANK_W]),
            .ev_q     (ev_all[b*BANK_W +: BANK_W]),
            .rise     (rise_all[b*BANK_W +: BANK_W]),
            .pend     (pend_bank[b])
        );
    end

    always_comb pend_any = |pend_bank;

    // Read mux: selected bank and register, zero when unmapped.
    always_comb begin
        rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (hit[b]) begin
                case (rsel)
                    REG_EVENT:  rdata = ev_all[b*BANK_W +: BANK_W];
                    REG_ENABLE: rdata = en_all[b*BANK_W +: BANK_W];
                    REG_LEVEL:  rdata = sync_all[b*BANK_W +: BANK_W];
                    default:    rdata = '0;
                endcase
            end
        end
    end

    // Registered request to the processor.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= pend_any;
    end
endmodule

// File: rtl/irq_ctrl_checker.sv
// Protocol and state checks for irq_banked_ctrl, attached by bind.
// Assumes bank 0 is the level-carrying bank at the highest offset.
module irq_ctrl_checker #(
    parameter int          NSRC   = 64,
    parameter int          BANK_W = 32,
    parameter int          ADDR_W = 6,
    parameter int          NBANK  = 2,
    parameter logic [31:0] LVL0   = 32'h3FF0_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:2] reg_addr,
    input logic [BANK_W-1:0] wdata,
    input logic              irq_o,
    input logic              pend_any,
    input logic [NSRC-1:0]   ev_all,
    input logic [NSRC-1:0]   en_all,
    input logic [NSRC-1:0]   rise_all
);
    localparam logic [ADDR_W-1:2] EN0  = (ADDR_W-2)'(NBANK*4 + 1);
    localparam logic [ADDR_W-1:2] ACK0 = (ADDR_W-2)'(NBANK*4 + 2);

    // R1: reset clears the request.
    a_r1_reset_clears_irq: assert property (@(posedge clk)
        !rst_n |=> !irq_o);

    // R9: request mirrors the combined pending state one cycle late.
    a_r9_irq_follows_pending: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq_o == $past(pend_any)));

    // R2: enable write to bank 0 is held.
    a_r2_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_addr == EN0) |=> (en_all[BANK_W-1:0] == $past(wdata)));

    // R5: acknowledged bits clear unless a new edge arrived.
    a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_addr == ACK0) |=>
        ((ev_all[BANK_W-1:0] & $past(wdata) & ~$past(rise_all[BANK_W-1:0])) == '0));

    // R4: a flag only rises on a source that was enabled.
    a_r4_flag_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((ev_all & ~$past(ev_all) & ~$past(en_all)) == '0));

    // R8: level sources never hold a flag.
    a_r8_level_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_all[BANK_W-1:0] & LVL0[BANK_W-1:0]) == '0);
endmodule

bind irq_banked_ctrl irq_ctrl_checker #(
    .NSRC   (NUM_BANKS*BANK_W),
    .BANK_W (BANK_W),
    .ADDR_W (ADDR_W),
    .NBANK  (NUM_BANKS),
    .LVL0   (irq_pkg::level_mask_f(0, ALT_LEVEL))
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .reg_addr (reg_addr),
    .wdata    (wdata),
    .irq_o    (irq_o),
    .pend_any (pend_any),
    .ev_all   (ev_all),
    .en_all   (en_all),
    .rise_all (rise_all)
);

// File: tb/tb_irq_banked_ctrl.sv
// Bench: behavioural reference model compared every cycle, plus
// directed checks per requirement.
module tb_irq_banked_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:2]  reg_addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [63:0] src_i = '0;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;
    string cur_req = "R1";

    localparam logic [63:0] LVL = 64'h0000_0000_3FF0_0000;

    // Reference model state.
    bit [63:0] m_s1, m_s2, m_prev, m_en, m_ev;
    bit        m_irq;

    irq_banked_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
        .wdata(wdata), .rdata(rdata), .src_i(src_i), .irq_o(irq_o)
    );

    always #4 clk = ~clk;

    function automatic int bank_of(logic [5:2] a);
        if (a[5:4] == 2'b10) return 0;
        if (a[5:4] == 2'b01) return 1;
        return -1;
    endfunction

    function automatic logic [31:0] mread(logic [5:2] a);
        int bk = bank_of(a);
        if (bk < 0) return 32'h0;
        case (a[3:2])
            2'd0: return m_ev[bk*32 +: 32];
            2'd1: return m_en[bk*32 +: 32];
            2'd3: return m_s2[bk*32 +: 32];
            default: return 32'h0;
        endcase
    endfunction

    // Model update on each clock edge.
    always @(posedge clk) begin
        bit [63:0] rise, ackm, nev, nen;
        bit        pend;
        int        bk;
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_prev = '0; m_en = '0; m_ev = '0; m_irq = 0;
        end else begin
            bk   = bank_of(reg_addr);
            rise = m_s2 & ~m_prev & ~LVL;
            ackm = '0;
            nen  = m_en;
            if (wr_en && bk >= 0 && reg_addr[3:2] == 2'd2) ackm[bk*32 +: 32] = wdata;
            if (wr_en && bk >= 0 && reg_addr[3:2] == 2'd1) nen[bk*32 +: 32] = wdata;
            pend  = |((m_ev | (m_s2 & LVL)) & m_en);
            nev   = (m_ev & ~ackm) | (rise & m_en);
            m_irq = pend;
            m_ev  = nev;
            m_en  = nen;
            m_prev = m_s2;
            m_s2  = m_s1;
            m_s1  = src_i;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Cycle compare after outputs settle.
    always @(posedge clk) begin
        #2;
        chk("R9", {31'b0, irq_o}, {31'b0, m_irq});
        chk(cur_req, rdata, mread(reg_addr));
    end

    task automatic wr(logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        reg_addr = a[5:2]; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(string req, logic [5:0] a, logic [31:0] mask, logic [31:0] exp);
        @(negedge clk);
        reg_addr = a[5:2];
        #1;
        chk(req, rdata & mask, exp);
        chk(req, rdata, mread(a[5:2]));
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(200000 * 8);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        idle(3);
        // R1: reset state.
        rd("R1", 6'h24, 32'hFFFF_FFFF, 32'h0);
        rd("R1", 6'h20, 32'hFFFF_FFFF, 32'h0);
        chk("R1", {31'b0, irq_o}, 32'h0);
        rst_n = 1'b1;
        idle(2);

        // R2: enable readback in both banks.
        cur_req = "R2";
        wr(6'h24, 32'h0000_00FF);
        rd("R2", 6'h24, 32'hFFFF_FFFF, 32'h0000_00FF);
        wr(6'h14, 32'hFFFF_0000);
        rd("R2", 6'h14, 32'hFFFF_FFFF, 32'hFFFF_0000);

        // R3: enabled edge latches, R9 request follows.
        cur_req = "R3";
        src_i[3] = 1'b1;
        idle(5);
        rd("R3", 6'h20, 32'h8, 32'h8);
        chk("R9", {31'b0, irq_o}, 32'h1);

        // R5: zero bits leave flags alone, one bits clear.
        cur_req = "R5";
        wr(6'h28, 32'h0000_0010);
        rd("R5", 6'h20, 32'h8, 32'h8);
        rd("R5", 6'h28, 32'hFFFF_FFFF, 32'h0);
        wr(6'h28, 32'h0000_0008);
        rd("R5", 6'h20, 32'h8, 32'h0);
        idle(3);
        chk("R5", {31'b0, irq_o}, 32'h0);

        // R4: disabled edge and enable-while-high latch nothing.
        cur_req = "R4";
        src_i[10] = 1'b1;
        idle(5);
        rd("R4", 6'h20, 32'h400, 32'h0);
        wr(6'h24, 32'h0000_04FF);
        idle(5);
        rd("R4", 6'h20, 32'h400, 32'h0);
        chk("R4", {31'b0, irq_o}, 32'h0);

        // R6: ack and new edge in the same cycle keep the flag.
        cur_req = "R6";
        src_i[5] = 1'b1;
        idle(5);
        rd("R6", 6'h20, 32'h20, 32'h20);
        src_i[5] = 1'b0;
        idle(5);
        @(negedge clk);
        src_i[5] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        reg_addr = 4'hA; wdata = 32'h20; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        rd("R6", 6'h20, 32'h20, 32'h20);
        wr(6'h28, 32'h20);
        rd("R6", 6'h20, 32'h20, 32'h0);
        idle(3);

        // R7: level register shows synchronized inputs of bank 1.
        cur_req = "R7";
        src_i[63:32] = 32'hA5A5_0000;
        idle(3);
        rd("R7", 6'h1C, 32'hFFFF_FFFF, 32'hA5A5_0000);
        rd("R7", 6'h2C, 32'h0000_0428, 32'h0000_0428);
        src_i[63:32] = 32'h0;
        idle(4);
        wr(6'h18, 32'hFFFF_FFFF);
        idle(2);

        // R8: level source 22 requests with no flag; bit 30 is edge.
        cur_req = "R8";
        wr(6'h24, 32'h4040_04FF);
        src_i[22] = 1'b1;
        idle(5);
        rd("R8", 6'h20, 32'h0040_0000, 32'h0);
        chk("R8", {31'b0, irq_o}, 32'h1);
        src_i[22] = 1'b0;
        idle(4);
        chk("R8", {31'b0, irq_o}, 32'h0);
        src_i[30] = 1'b1;
        idle(5);
        rd("R8", 6'h20, 32'h4000_0000, 32'h4000_0000);
        chk("R8", {31'b0, irq_o}, 32'h1);

        // R11: clearing enables drops the request, flags remain.
        cur_req = "R11";
        wr(6'h24, 32'h0);
        wr(6'h14, 32'h0);
        idle(2);
        chk("R11", {31'b0, irq_o}, 32'h0);
        rd("R11", 6'h20, 32'h4000_0000, 32'h4000_0000);

        // R10: unmapped offsets read 0 and ignore writes.
        cur_req = "R10";
        wr(6'h34, 32'hFFFF_FFFF);
        wr(6'h04, 32'hFFFF_FFFF);
        rd("R10", 6'h34, 32'hFFFF_FFFF, 32'h0);
        rd("R10", 6'h00, 32'hFFFF_FFFF, 32'h0);
        rd("R10", 6'h24, 32'hFFFF_FFFF, 32'h0);
        rd("R10", 6'h14, 32'hFFFF_FFFF, 32'h0);
        idle(2);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule